// File: doc/BRIEF.md
# Branch Direction Predictor

This block guesses whether a branch will be taken, before the branch resolves. A lookup port takes the branch's program counter and a two-bit branch kind. It answers with a taken/not-taken guess in the same cycle, using combinational logic only. An update port takes the resolved outcome for a program counter. It folds that outcome into a small direct-mapped table of per-entry state.

A run-time mode input selects one of four policies:
- always guess not taken;
- guess from the branch kind;
- take a majority vote over the entry's most recent outcomes;
- follow a saturating two-bit counter per entry.

Every entry keeps both its outcome history and its two-bit counter up to date in all modes. The mode can therefore change at any time without retraining.

The block also counts resolved updates and, among them, the ones whose pre-update guess matched the outcome. A scripted outcome stream can then be scored for accuracy.

Top module: `brPredictor`

## Requirements
- R1: After reset every entry holds counter state 01 and an all-zero (all not-taken) history, and both the hit and total counters read zero, so every lookup in history and two-bit modes guesses not taken.
- R2: With mode 00 (fixed) the guess is always not taken, whatever the table holds.
- R3: With mode 01 (static) a kind of 01 (conditional) guesses not taken, and the kinds 00 (unconditional), 10 (loop) and 11 (call/return) guess taken.
- R4: With mode 10 (history) the guess is taken when at least (HIST_N+1)/2 of the entry's last HIST_N outcomes were taken; for HIST_N = 3 that means two or more of three.
- R5: An update shifts the outcome into the addressed entry's history as the newest bit (bit 0) and leaves every other entry unchanged.
- R6: With mode 11 (two-bit) counter states 00 and 01 guess not taken and states 10 and 11 guess taken.
- R7: Every update steps the entry's counter one step toward 11 on taken and toward 00 on not taken, saturating at both ends, so one opposite outcome from a strong state does not flip the guess.
- R8: A lookup to the same entry in the cycle of an update sees the state from before that update; the new state is visible from the next cycle.
- R9: The entry index is PC bits [ALIGN_W +: IDX_W] (bits 5:2 by default); addresses differing only in the alignment bits or above the index share an entry.
- R10: Each update adds one to the total counter, and adds one to the hit counter when the guess for that entry, under the current mode and the update's branch kind and before the update, equals the outcome.
- R11: Changing the mode alters no stored state; history and counter are trained in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 00 fixed, 01 static, 10 history, 11 two-bit |
| lkPc | input | PC_W | Lookup program counter |
| lkKind | input | 2 | Lookup branch kind |
| predTaken | output | 1 | Guess for the lookup, combinational |
| upValid | input | 1 | Update strobe |
| upPc | input | PC_W | Program counter of the resolved branch |
| upKind | input | 2 | Branch kind of the resolved branch |
| upTaken | input | 1 | Resolved outcome, 1 = taken |
| hitCnt | output | CNT_W | Updates whose guess matched the outcome |
| totalCnt | output | CNT_W | Updates seen since reset |

## Verification
The bench feeds outcome streams that separate the policies from one another.

A taken-taken-not-taken-not-taken stream on one entry shows the majority vote falling back after two misses. On the same stream the two-bit counter keeps guessing taken after the first miss, because it holds the saturated strong state.

Alternating outcomes separate the history window from the counter's hysteresis. Probing all four kinds under static and fixed modes covers the kind decoding.

Aliased and neighbouring addresses show that an update reaches exactly one entry. A lookup held on the updated entry during the update cycle shows the pre-update value. A reference model in the bench tracks the expected hit and total counts over the whole run.

// File: rtl/bpPkg.sv
package bpPkg;
  typedef enum logic [1:0] {
    MODE_FIXED  = 2'b00,
    MODE_STATIC = 2'b01,
    MODE_HIST   = 2'b10,
    MODE_TWOBIT = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    KIND_UNCOND  = 2'b00,
    KIND_COND    = 2'b01,
    KIND_LOOP    = 2'b10,
    KIND_CALLRET = 2'b11
  } kindT;

  typedef struct packed {
    logic wrEn;
    logic wrTaken;
    logic cntTotal;
    logic cntHit;
  } strobeT;
endpackage

// File: rtl/bpPolicy.sv
module bpPolicy #(
  parameter int HIST_N = 3
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        kind,
  input  logic [HIST_N-1:0] hist,
  input  logic [1:0]        state,
  output logic              pred
);
  import bpPkg::*;
  localparam int THR = (HIST_N + 1) / 2;
  localparam int CW  = $clog2(HIST_N + 1);

  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_N; i++) ones = ones + CW'(hist[i]);
  end

  always_comb begin
    case (modeT'(mode))
      MODE_FIXED:  pred = 1'b0;
      MODE_STATIC: pred = (kindT'(kind) != KIND_COND);
      MODE_HIST:   pred = (int'(ones) >= THR);
      default:     pred = state[1];
    endcase
  end
endmodule

// File: rtl/bpCtrl.sv
module bpCtrl #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   lkPc,
  input  logic              upValid,
  input  logic [PC_W-1:0]   upPc,
  input  logic              upTaken,
  input  logic              upPredCur,
  output logic [IDX_W-1:0]  lkIdx,
  output logic [IDX_W-1:0]  upIdx,
  output bpPkg::strobeT     strobe
);
  assign lkIdx = lkPc[ALIGN_W +: IDX_W];
  assign upIdx = upPc[ALIGN_W +: IDX_W];

  always_comb begin
    strobe.wrEn     = upValid;
    strobe.wrTaken  = upTaken;
    strobe.cntTotal = upValid;
    strobe.cntHit   = upValid && (upPredCur == upTaken);
  end

  AST_HIT_NEEDS_UPD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntHit |-> strobe.cntTotal); // R10
endmodule

// File: rtl/bpTable.sv
module bpTable #(
  parameter int IDX_W  = 4,
  parameter int HIST_N = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpPkg::strobeT     strobe,
  input  logic [IDX_W-1:0]  lkIdx,
  input  logic [IDX_W-1:0]  upIdx,
  output logic [HIST_N-1:0] lkHist,
  output logic [1:0]        lkState,
  output logic [HIST_N-1:0] upHist,
  output logic [1:0]        upState,
  output logic [CNT_W-1:0]  hitCnt,
  output logic [CNT_W-1:0]  totalCnt
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [HIST_N-1:0] histQ  [ENTRIES];
  logic [1:0]        stateQ [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : gEntry
    logic sel;
    assign sel = strobe.wrEn && (upIdx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        histQ[e]  <= '0;
        stateQ[e] <= 2'b01;
      end else if (sel) begin
        histQ[e] <= {histQ[e], strobe.wrTaken};
        if (strobe.wrTaken)
          stateQ[e] <= (stateQ[e] == 2'b11) ? 2'b11 : stateQ[e] + 2'b01;
        else
          stateQ[e] <= (stateQ[e] == 2'b00) ? 2'b00 : stateQ[e] - 2'b01;
      end
    end
  end

  assign lkHist  = histQ[lkIdx];
  assign lkState = stateQ[lkIdx];
  assign upHist  = histQ[upIdx];
  assign upState = stateQ[upIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitCnt   <= '0;
      totalCnt <= '0;
    end else begin
      if (strobe.cntTotal) totalCnt <= totalCnt + 1'b1;
      if (strobe.cntHit)   hitCnt   <= hitCnt + 1'b1;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> histQ[$past(upIdx)][0] == $past(strobe.wrTaken)); // R5
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrTaken && upState == 2'b11) |=> stateQ[$past(upIdx)] == 2'b11); // R7
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.wrTaken && upState == 2'b00) |=> stateQ[$past(upIdx)] == 2'b00); // R7
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntTotal |=> totalCnt == CNT_W'($past(totalCnt) + 1'b1)); // R10
  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cntHit |=> $stable(hitCnt)); // R10
endmodule

// File: rtl/brPredictor.sv
module brPredictor #(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int ALIGN_W = 2,
  parameter int HIST_N  = 3,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [PC_W-1:0]  lkPc,
  input  logic [1:0]       lkKind,
  output logic             predTaken,
  input  logic             upValid,
  input  logic [PC_W-1:0]  upPc,
  input  logic [1:0]       upKind,
  input  logic             upTaken,
  output logic [CNT_W-1:0] hitCnt,
  output logic [CNT_W-1:0] totalCnt
);
  import bpPkg::*;

  strobeT            strobe;
  logic [IDX_W-1:0]  lkIdx, upIdx;
  logic [HIST_N-1:0] lkHist, upHist;
  logic [1:0]        lkState, upState;
  logic              upPredCur;

  bpCtrl #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN_W(ALIGN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .upValid(upValid), .upPc(upPc),
    .upTaken(upTaken), .upPredCur(upPredCur), .lkIdx(lkIdx), .upIdx(upIdx),
    .strobe(strobe));

  bpTable #(.IDX_W(IDX_W), .HIST_N(HIST_N), .CNT_W(CNT_W)) uTable (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lkIdx(lkIdx), .upIdx(upIdx),
    .lkHist(lkHist), .lkState(lkState), .upHist(upHist), .upState(upState),
    .hitCnt(hitCnt), .totalCnt(totalCnt));

  bpPolicy #(.HIST_N(HIST_N)) uLkPolicy (
    .mode(mode), .kind(lkKind), .hist(lkHist), .state(lkState), .pred(predTaken));

  bpPolicy #(.HIST_N(HIST_N)) uUpPolicy (
    .mode(mode), .kind(upKind), .hist(upHist), .state(upState), .pred(upPredCur));

  AST_FIXED_NT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b00) |-> !predTaken); // R2
  AST_STATIC_KIND: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01) |-> predTaken == (lkKind != 2'b01)); // R3
  AST_TWOBIT_DIR: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b11) |-> predTaken == lkState[1]); // R6
endmodule

// File: tb/brPredictor_test.sv
module brPredictor_test;
  localparam int PC_W = 32;
  localparam int CNT_W = 16;

  logic clk = 0;
  logic rstN = 0;
  logic [1:0] mode = 0;
  logic [PC_W-1:0] lkPc = 0, upPc = 0;
  logic [1:0] lkKind = 0, upKind = 0;
  logic upValid = 0, upTaken = 0;
  logic predTaken;
  logic [CNT_W-1:0] hitCnt, totalCnt;

  int total = 0, bad = 0;
  int expHit = 0, expTot = 0;
  logic [2:0] mHist [16];
  logic [1:0] mState [16];

  always #10 clk = ~clk;

  brPredictor uut (
    .clk(clk), .rstN(rstN), .mode(mode), .lkPc(lkPc), .lkKind(lkKind),
    .predTaken(predTaken), .upValid(upValid), .upPc(upPc), .upKind(upKind),
    .upTaken(upTaken), .hitCnt(hitCnt), .totalCnt(totalCnt));

  function automatic logic modelPred(logic [1:0] m, logic [1:0] k, int idx);
    int c = int'(mHist[idx][0]) + int'(mHist[idx][1]) + int'(mHist[idx][2]);
    case (m)
      2'b00: return 1'b0;
      2'b01: return k != 2'b01;
      2'b10: return c >= 2;
      default: return mState[idx][1];
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic [1:0] k, input logic exp, input string tag);
    lkPc = pc; lkKind = k;
    #1;
    check(32'(predTaken), 32'(exp), tag);
  endtask

  task automatic doUpdate(input logic [31:0] pc, input logic [1:0] k, input logic t);
    int idx = int'(pc[5:2]);
    expTot++;
    if (modelPred(mode, k, idx) == t) expHit++;
    upPc = pc; upKind = k; upTaken = t; upValid = 1;
    @(negedge clk);
    upValid = 0;
    mHist[idx] = {mHist[idx][1:0], t};
    if (t) mState[idx] = (mState[idx] == 2'b11) ? 2'b11 : mState[idx] + 2'b01;
    else   mState[idx] = (mState[idx] == 2'b00) ? 2'b00 : mState[idx] - 2'b01;
  endtask

  task automatic testReset();
    for (int i = 0; i < 16; i++) begin mHist[i] = 0; mState[i] = 2'b01; end
    check(32'(totalCnt), 0, "R1 total");
    check(32'(hitCnt), 0, "R1 hit");
    mode = 2'b11; lookup(32'h0, 2'b01, 0, "R1 twobit");
    lookup(32'h3C, 2'b10, 0, "R1 twobit last");
    mode = 2'b10; lookup(32'h20, 2'b00, 0, "R1 history");
  endtask

  task automatic testStatic();
    mode = 2'b01;
    lookup(32'h4, 2'b00, 1, "R3 uncond");
    lookup(32'h4, 2'b01, 0, "R3 cond");
    lookup(32'h4, 2'b10, 1, "R3 loop");
    lookup(32'h4, 2'b11, 1, "R3 callret");
  endtask

  task automatic testHistory();
    mode = 2'b10;
    doUpdate(32'h8, 2'b01, 1); lookup(32'h8, 2'b01, 0, "R4 one of three");
    doUpdate(32'h8, 2'b01, 1); lookup(32'h8, 2'b01, 1, "R4 two of three");
    doUpdate(32'h8, 2'b01, 0); lookup(32'h8, 2'b01, 1, "R4 110");
    doUpdate(32'h8, 2'b01, 0); lookup(32'h8, 2'b01, 0, "R4 100");
    doUpdate(32'h8, 2'b01, 1); lookup(32'h8, 2'b01, 0, "R4 001");
    doUpdate(32'h8, 2'b01, 0); lookup(32'h8, 2'b01, 0, "R4 010");
    doUpdate(32'h8, 2'b01, 1); lookup(32'h8, 2'b01, 1, "R4 101");
    mode = 2'b11; lookup(32'h8, 2'b01, modelPred(2'b11, 2'b01, 2), "R11 counter trained in history mode");
  endtask

  task automatic testTwoBit();
    mode = 2'b11;
    doUpdate(32'h10, 2'b01, 1); lookup(32'h10, 2'b01, 1, "R6 state10");
    doUpdate(32'h10, 2'b01, 1);
    doUpdate(32'h10, 2'b01, 1);
    doUpdate(32'h10, 2'b01, 0); lookup(32'h10, 2'b01, 1, "R7 one miss from strong");
    doUpdate(32'h10, 2'b01, 0); lookup(32'h10, 2'b01, 0, "R7 second miss");
    doUpdate(32'h10, 2'b01, 0);
    doUpdate(32'h10, 2'b01, 0);
    doUpdate(32'h10, 2'b01, 1); lookup(32'h10, 2'b01, 0, "R7 one taken from strong NT");
    doUpdate(32'h10, 2'b01, 1); lookup(32'h10, 2'b01, 1, "R6 back to 10");
    mode = 2'b10; lookup(32'h10, 2'b01, modelPred(2'b10, 2'b01, 4), "R11 history kept");
  endtask

  task automatic testFixed();
    mode = 2'b00;
    lookup(32'h10, 2'b00, 0, "R2 trained entry");
    lookup(32'h10, 2'b10, 0, "R2 loop kind");
  endtask

  task automatic testSameCycle();
    mode = 2'b11;
    lkPc = 32'h18; lkKind = 2'b01;
    upPc = 32'h18; upKind = 2'b01; upTaken = 1; upValid = 1;
    #1; check(32'(predTaken), 0, "R8 pre-update view");
    expTot++; if (modelPred(mode, 2'b01, 6) == 1'b1) expHit++;
    @(negedge clk); upValid = 0;
    mHist[6] = {mHist[6][1:0], 1'b1}; mState[6] = 2'b10;
    #1; check(32'(predTaken), 1, "R8 next cycle");
  endtask

  task automatic testAlias();
    mode = 2'b11;
    doUpdate(32'h14, 2'b00, 1);
    lookup(32'h17, 2'b00, 1, "R9 alignment bits ignored");
    lookup(32'h54, 2'b00, 1, "R9 upper bits alias");
    lookup(32'h1C, 2'b00, 0, "R5 neighbour untouched");
    lookup(32'h0, 2'b00, 0, "R5 entry zero untouched");
  endtask

  task automatic testCounters();
    check(32'(totalCnt), 32'(expTot), "R10 total");
    check(32'(hitCnt), 32'(expHit), "R10 hit");
    mode = 2'b01;
    doUpdate(32'h24, 2'b10, 1);
    doUpdate(32'h24, 2'b01, 1);
    mode = 2'b00;
    doUpdate(32'h24, 2'b00, 0);
    check(32'(totalCnt), 32'(expTot), "R10 total after mixed modes");
    check(32'(hitCnt), 32'(expHit), "R10 hit after mixed modes");
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rstN = 1;
        @(negedge clk);
        testReset();
        testStatic();
        testHistory();
        testTwoBit();
        testFixed();
        testSameCycle();
        testAlias();
        testCounters();
      end
      begin
        repeat (5000) @(negedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule